// File: doc/BRIEF.md
# Key-Combination and Pin Reset Controller

This block produces the internal system reset of a low-power chip from two independent requests. An active-low reset pin drives a set/reset latch, so any low level on the pin, however short, puts the chip into reset at once. The latch is released only on a slow strobe. That strobe is divided down from the 32.768 kHz low-speed clock and runs at 2 Hz, so release happens up to half a second after the pin goes high again.

The second request is a group of four active-low key inputs. A compile-time choice selects which keys must be held down together: none (feature off), keys 0 and 1, keys 0 to 2, or all four. The combined press must survive a noise filter, which is a run of consecutive low-clock cycles. When long-press qualification is enabled, it must also be held across a set number of 1 Hz strobes, giving a hold time between one and two seconds. When the press is accepted, the reset latch is set and stays set until the keys are let go and the next 2 Hz strobe arrives.

A separate power-up clear input starts the divider and the filter counters. The divider is never cleared by the reset it produces, so the release strobe keeps its rhythm while the chip is in reset. A one-cycle release event marks the end of each reset.

Top module: `keyRstCtrl`

## Requirements
- R1: A low level on `pinN` drives `rstOut` high immediately, without waiting for a clock edge.
- R2: After `pinN` returns high, `rstOut` falls only on a 2 Hz strobe (one cycle in every 2^DIV_BITS), and only once the pin level has passed a two-flop synchronizer. Release therefore comes between 2 and 2^DIV_BITS+2 cycles after the pin rises.
- R3: A `pinN` low pulse shorter than one clock period is still captured, and `rstOut` stays high afterwards until a release strobe.
- R4: When every key selected by COMBO is low (0 = pressed; bit i of `keysN` is key i) for FILT_CYCLES consecutive cycles, and qualification is off, `rstOut` rises on the next clock edge. With COMBO = COMBO_OFF, keys never cause reset.
- R5: A combined press shorter than FILT_CYCLES cycles, or one broken by any selected key going high, has no effect on `rstOut`.
- R6: Keys outside the selected group are ignored. They neither block a valid combination nor create one.
- R7: With HOLD_EN set, a filtered press asserts reset only after HOLD_TICKS 1 Hz strobes (one cycle in every 2^(DIV_BITS+1)) have occurred while the filtered press is held. Any earlier release of a key restarts the count.
- R8: `relEvt` is a single-cycle pulse that is high exactly in the first cycle in which `rstOut` is low after a reset.
- R9: The divider is cleared only by `porN`, so release strobes stay on a fixed grid counted from power-up, whatever resets occur in between.
- R10: While `porN` is low, `rstOut` is high and `relEvt` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz low-speed clock |
| porN | input | 1 | Active-low power-up clear for divider and counters |
| pinN | input | 1 | Active-low external reset pin |
| keysN | input | 4 | Active-low key inputs, bit i is key i |
| rstOut | output | 1 | Internal reset, active high |
| relEvt | output | 1 | One-cycle pulse marking reset release |

## Verification
The checker assumes that `porN` is pulsed low once before anything else happens and then stays high. It also assumes the key inputs already arrive synchronous to `clk`. The bench drives both kinds of input only on falling clock edges, after the power-up pulse. The reset pin is treated as fully asynchronous, and the stimulus includes sub-cycle pin pulses placed between edges. Random segments mix pin pulses of random length, noisy key patterns and long combined presses, so that releases fall on many different divider phases.

// File: rtl/keyRstPkg.sv
package keyRstPkg;

  typedef enum logic [1:0] {
    COMBO_OFF   = 2'd0,
    COMBO_K01   = 2'd1,
    COMBO_K012  = 2'd2,
    COMBO_K0123 = 2'd3
  } comboSel_e;

  // strobes from control into the datapath hold counter
  typedef struct packed {
    logic holdClear;
    logic holdStep;
  } ctlStrobes_t;

  function automatic logic [3:0] comboMask(comboSel_e sel);
    case (sel)
      COMBO_K01:   return 4'b0011;
      COMBO_K012:  return 4'b0111;
      COMBO_K0123: return 4'b1111;
      default:     return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/keyRstDatapath.sv
module keyRstDatapath
  import keyRstPkg::*;
#(
  parameter comboSel_e COMBO       = COMBO_K0123,
  parameter int        DIV_BITS    = 14,
  parameter int        FILT_CYCLES = 49,
  parameter int        HOLD_TICKS  = 2
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        pinN,
  input  logic [3:0]  keysN,
  input  ctlStrobes_t ctl,
  output logic        tick2,
  output logic        tick1,
  output logic        pinHigh,
  output logic        filtOk,
  output logic        holdOk
);

  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [FW-1:0] FILT_MAX = FW'(FILT_CYCLES);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_TICKS);
  localparam logic [3:0]    KMASK    = comboMask(COMBO);

  // free-running divider, cleared only at power-up
  logic [DIV_BITS:0] divCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign tick2 = &divCnt[DIV_BITS-1:0];
  assign tick1 = &divCnt;

  // pin release synchronizer, cleared asynchronously while the pin is low
  logic [1:0] pinSync;

  always_ff @(posedge clk or negedge pinN) begin
    if (!pinN) pinSync <= 2'b00;
    else       pinSync <= {pinSync[0], 1'b1};
  end

  assign pinHigh = pinSync[1];

  // combination detect
  logic keysLow;

  generate
    if (COMBO == COMBO_OFF) begin : gNoCombo
      assign keysLow = 1'b0;
    end else begin : gCombo
      assign keysLow = &((~keysN) | (~KMASK));
    end
  endgenerate

  // noise filter: consecutive low cycles, saturating
  logic [FW-1:0] filtCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              filtCnt <= '0;
    else if (!keysLow)      filtCnt <= '0;
    else if (filtCnt != FILT_MAX) filtCnt <= filtCnt + 1'b1;
  end

  assign filtOk = (filtCnt == FILT_MAX);

  // long-press qualification counter, stepped by control
  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              holdCnt <= '0;
    else if (ctl.holdClear) holdCnt <= '0;
    else if (ctl.holdStep)  holdCnt <= holdCnt + 1'b1;
  end

  assign holdOk = (holdCnt == HOLD_MAX);

endmodule

// File: rtl/keyRstControl.sv
module keyRstControl
  import keyRstPkg::*;
#(
  parameter bit HOLD_EN = 1'b1
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        pinN,
  input  logic        tick2,
  input  logic        tick1,
  input  logic        pinHigh,
  input  logic        filtOk,
  input  logic        holdOk,
  output ctlStrobes_t ctl,
  output logic        rstOut,
  output logic        relEvt
);

  logic setN;
  logic keyReq;
  logic releaseNow;

  assign setN       = pinN & porN;
  assign keyReq     = HOLD_EN ? holdOk : filtOk;
  assign releaseNow = rstOut & ~keyReq & tick2 & pinHigh;

  always_comb begin
    ctl.holdClear = ~filtOk;
    ctl.holdStep  = filtOk & tick1 & ~holdOk;
  end

  // set/reset latch: asynchronous set, release on the slow strobe
  always_ff @(posedge clk or negedge setN) begin
    if (!setN)            rstOut <= 1'b1;
    else if (keyReq)      rstOut <= 1'b1;
    else if (releaseNow)  rstOut <= 1'b0;
  end

  always_ff @(posedge clk or negedge setN) begin
    if (!setN) relEvt <= 1'b0;
    else       relEvt <= releaseNow;
  end

endmodule

// File: rtl/keyRstCtrl.sv
module keyRstCtrl
  import keyRstPkg::*;
#(
  parameter comboSel_e COMBO       = COMBO_K0123,
  parameter bit        HOLD_EN     = 1'b1,
  parameter int        DIV_BITS    = 14,
  parameter int        FILT_CYCLES = 49,
  parameter int        HOLD_TICKS  = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       pinN,
  input  logic [3:0] keysN,
  output logic       rstOut,
  output logic       relEvt
);

  ctlStrobes_t ctl;
  logic tick2, tick1, pinHigh, filtOk, holdOk;

  keyRstDatapath #(
    .COMBO(COMBO), .DIV_BITS(DIV_BITS),
    .FILT_CYCLES(FILT_CYCLES), .HOLD_TICKS(HOLD_TICKS)
  ) uDp (
    .clk(clk), .porN(porN), .pinN(pinN), .keysN(keysN), .ctl(ctl),
    .tick2(tick2), .tick1(tick1), .pinHigh(pinHigh),
    .filtOk(filtOk), .holdOk(holdOk)
  );

  keyRstControl #(.HOLD_EN(HOLD_EN)) uCtl (
    .clk(clk), .porN(porN), .pinN(pinN),
    .tick2(tick2), .tick1(tick1), .pinHigh(pinHigh),
    .filtOk(filtOk), .holdOk(holdOk), .ctl(ctl),
    .rstOut(rstOut), .relEvt(relEvt)
  );

endmodule

// File: rtl/keyRstChecker.sv
module keyRstChecker #(
  parameter int DIV_BITS = 14
) (
  input logic clk,
  input logic porN,
  input logic pinN,
  input logic rstOut,
  input logic relEvt
);

  // independent phase counter, started at power-up
  logic [DIV_BITS-1:0] phase;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  assert_pin_low_R1: assert property (@(posedge clk) disable iff (!porN)
    !pinN |-> rstOut);

  assert_hold_off_grid_R2: assert property (@(posedge clk) disable iff (!porN)
    (rstOut && phase != {DIV_BITS{1'b1}}) |=> rstOut);

  assert_release_grid_R9: assert property (@(posedge clk) disable iff (!porN)
    relEvt |-> (phase == '0));

  assert_release_single_R8: assert property (@(posedge clk) disable iff (!porN)
    relEvt |=> !relEvt);

  assert_release_marks_fall_R8: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstOut) |-> relEvt);

  assert_release_low_R8: assert property (@(posedge clk) disable iff (!porN)
    relEvt |-> !rstOut);

endmodule

bind keyRstCtrl keyRstChecker #(.DIV_BITS(DIV_BITS)) uChk (
  .clk(clk), .porN(porN), .pinN(pinN), .rstOut(rstOut), .relEvt(relEvt)
);

// File: tb/sim_keyRstCtrl.sv
module sim_keyRstCtrl;
  import keyRstPkg::*;

  localparam int DB   = 4;
  localparam int FILT = 5;
  localparam int HOLD = 2;
  localparam int P2   = 1 << DB;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic pinN = 1'b0;
  logic [3:0] keysN = 4'hF;
  logic rst0, rel0, rst1, rel1;

  always #4 clk = ~clk;

  keyRstCtrl #(.COMBO(COMBO_K0123), .HOLD_EN(1'b1), .DIV_BITS(DB),
               .FILT_CYCLES(FILT), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .porN(porN), .pinN(pinN), .keysN(keysN),
    .rstOut(rst0), .relEvt(rel0));

  keyRstCtrl #(.COMBO(COMBO_K01), .HOLD_EN(1'b0), .DIV_BITS(DB),
               .FILT_CYCLES(FILT), .HOLD_TICKS(HOLD)) u1 (
    .clk(clk), .porN(porN), .pinN(pinN), .keysN(keysN),
    .rstOut(rst1), .relEvt(rel1));

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  int  mDiv[2], mS0[2], mS1[2], mFilt[2], mHold[2], mLatch[2], mRel[2];
  logic [3:0] mMask[2] = '{4'hF, 4'h3};
  bit  mHoldEn[2] = '{1'b1, 1'b0};
  bit  pinLowSeen = 0;

  always @(negedge pinN) pinLowSeen = 1;

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit t2, t1, fOk, hOk, kReq, kLow;
      int nDiv, nFilt, nHold, nLatch, nRel, nS0, nS1;
      if (pinLowSeen) begin mLatch[i] = 1; mS0[i] = 0; mS1[i] = 0; mRel[i] = 0; end
      t2   = ((mDiv[i] % P2) == P2 - 1);
      t1   = (mDiv[i] == 2 * P2 - 1);
      fOk  = (mFilt[i] == FILT);
      hOk  = (mHold[i] == HOLD);
      kReq = mHoldEn[i] ? hOk : fOk;
      kLow = (mMask[i] != 0) && ((keysN & mMask[i]) == 4'h0);
      nDiv  = (mDiv[i] + 1) % (2 * P2);
      nS0   = 1;
      nS1   = mS0[i];
      nFilt = !kLow ? 0 : (mFilt[i] < FILT ? mFilt[i] + 1 : FILT);
      nHold = !fOk ? 0 : ((t1 && !hOk) ? mHold[i] + 1 : mHold[i]);
      nRel  = mLatch[i] && !kReq && t2 && mS1[i];
      nLatch = kReq ? 1 : (nRel ? 0 : mLatch[i]);
      if (!pinN) begin nS0 = 0; nS1 = 0; nLatch = 1; nRel = 0; end
      if (!porN) begin nDiv = 0; nFilt = 0; nHold = 0; nLatch = 1; nRel = 0; end
      mDiv[i] = nDiv; mS0[i] = nS0; mS1[i] = nS1; mFilt[i] = nFilt;
      mHold[i] = nHold; mLatch[i] = nLatch; mRel[i] = nRel;
    end
    pinLowSeen = 0;
  end

  // per-cycle comparison, away from both clock edges
  always @(posedge clk) begin
    #2;
    if (porN && !done) begin
      int eR0, eR1, eE0, eE1;
      eR0 = (mLatch[0] != 0) || !pinN;
      eR1 = (mLatch[1] != 0) || !pinN;
      eE0 = (mRel[0] != 0) && pinN;
      eE1 = (mRel[1] != 0) && pinN;
      check(rst0 == eR0, "R2/R7/R9 u0 rstOut", rst0, eR0);
      check(rst1 == eR1, "R2/R4/R9 u1 rstOut", rst1, eR1);
      check(rel0 == eE0, "R8 u0 relEvt", rel0, eE0);
      check(rel1 == eE1, "R8 u1 relEvt", rel1, eE1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    int rise;
    void'($urandom(32'd20240607));
    // power-up
    cyc(3);
    check(rst0 == 1 && rst1 == 1, "R10 rstOut during porN", rst0 & rst1, 1);
    check(rel0 == 0 && rel1 == 0, "R10 relEvt during porN", rel0 | rel1, 0);
    porN = 1'b1;
    pinN = 1'b1;
    // release timing after pin high
    rise = 0;
    for (int k = 0; k < P2 + 4; k++) begin
      cyc(1);
      if (!rst0) break;
      rise++;
    end
    check(rst0 == 0, "R2 released after pin high", rst0, 0);
    check(rise >= 1 && rise <= P2 + 2, "R2 release latency in cycles", rise, P2);
    check(rel0 == 1, "R8 relEvt in first low cycle", rel0, 1);
    cyc(1);
    check(rel0 == 0, "R8 relEvt single cycle", rel0, 0);
    cyc(10);

    // R1: immediate assertion
    pinN = 1'b0;
    #1;
    check(rst0 == 1 && rst1 == 1, "R1 async assert", rst0 & rst1, 1);
    cyc(1);
    pinN = 1'b1;
    cyc(3 * P2);
    check(rst0 == 0, "R2 release after R1 test", rst0, 0);

    // R3: sub-cycle pulse
    pinN = 1'b0;
    #1;
    pinN = 1'b1;
    cyc(1);
    check(rst0 == 1 && rst1 == 1, "R3 short pulse captured", rst0 & rst1, 1);
    cyc(3 * P2);
    check(rst0 == 0, "R3 later release", rst0, 0);

    // R5: press too short
    keysN = 4'b1100;
    cyc(FILT - 1);
    keysN = 4'hF;
    cyc(10);
    check(rst1 == 0, "R5 short press ignored", rst1, 0);
    // R5: press broken by a bounce
    keysN = 4'b1100; cyc(3); keysN = 4'b1101; cyc(1); keysN = 4'b1100; cyc(3);
    keysN = 4'hF; cyc(5);
    check(rst1 == 0, "R5 broken press ignored", rst1, 0);

    // R4: two-key combo on u1, exact timing
    keysN = 4'b1100;
    cyc(FILT);
    check(rst1 == 0, "R4 not before filter done", rst1, 0);
    cyc(1);
    check(rst1 == 1, "R4 combo asserts reset", rst1, 1);
    check(rst0 == 0, "R6 u0 incomplete combo ignored", rst0, 0);
    keysN = 4'hF;
    cyc(3 * P2);
    check(rst1 == 0, "R4 released after keys up", rst1, 0);

    // R6: unselected keys toggling do not block
    for (int k = 0; k < FILT + 3; k++) begin
      keysN = {2'($urandom), 2'b00};
      cyc(1);
    end
    check(rst1 == 1, "R6 noisy unselected keys", rst1, 1);
    keysN = 4'hF;
    cyc(3 * P2);
    keysN = 4'b0011;
    cyc(20);
    check(rst1 == 0, "R6 unselected keys alone", rst1, 0);
    keysN = 4'hF;
    cyc(3 * P2);

    // R7: long press on u0
    keysN = 4'h0;
    cyc(FILT + 3);
    check(rst0 == 0, "R7 filtered but not yet held", rst0, 0);
    cyc(4 * P2 + 4);
    check(rst0 == 1, "R7 long press asserts", rst0, 1);
    keysN = 4'hF;
    cyc(4 * P2);
    check(rst0 == 0, "R7 released after long press", rst0, 0);

    // random segments
    for (int s = 0; s < 1500; s++) begin
      int mode, len;
      mode = $urandom_range(0, 5);
      len  = $urandom_range(1, 40);
      case (mode)
        0: begin pinN = 1'b0; cyc($urandom_range(1, 6)); pinN = 1'b1; end
        1: begin pinN = 1'b0; #1; pinN = 1'b1; cyc(1); end
        2: for (int k = 0; k < len; k++) begin keysN = 4'($urandom); cyc(1); end
        3: begin keysN = {2'($urandom), 2'b00}; cyc(len); end
        4: begin keysN = 4'h0; cyc($urandom_range(10, 4 * P2 + 20)); end
        default: begin keysN = 4'hF; cyc(len); end
      endcase
    end
    keysN = 4'hF;
    cyc(4 * P2);
    done = 1;
    summary();
    $finish;
  end

endmodule